// File: doc/BRIEF.md
# Temperature Threshold Alert Latch

This block watches a stream of signed 16-bit temperature results, one LSB per 0.01 °C, and compares every freshly finished conversion against an upper and a lower trip point. Each trip point comes from an 8-bit code held elsewhere. The code is decoded on a coarse grid of 0.64 °C (64 LSB) steps, centred so that code 63 means 0 °C. A code of zero switches that trip point off.

A trip raises a sticky status flag and latches an alert. The alert drives an active-low open-drain pin through an enable output. Software drops the alert in one of two ways: by reading the status byte, which also clears both flags, or by an alert-response acknowledge, which clears only the alert. The alert is never raised again merely because the condition persists. It is raised only when a later conversion completes while the condition still holds. The bus protocol and the conversion timing are handled outside this block.

Top module: `temp_alert_top`

## Requirements
- R1: The upper trip point in LSB is (hiLimitCode − 63) × 64. A conversion trips high when the temperature is greater than or equal to it. For example, code 63 trips at 0 and not at −1, and code 255 trips at 12288 and not at 12287.
- R2: A limit code of 0 disables that comparison. No value of the temperature, from −32768 to 32767, sets the matching flag or the alert.
- R3: The lower trip point in LSB is (loLimitCode − 63) × 64. A conversion trips low only when the temperature is strictly below it. For example, code 1 trips at −3969 and not at −3968.
- R4: statusBits bit 1 is the over flag, bit 2 is the under flag, and every other bit reads 0. Once a flag is set, it stays set through later conversions that do not trip.
- R5: A one-cycle statusRead pulse clears both flags. The cleared value is seen in the cycle after the pulse.
- R6: A tripping conversion sets alertPullLow and alertPending in the cycle after convDone. Both stay high until an acknowledge or a status read.
- R7: An alertAck pulse clears the alert but leaves the status flags unchanged.
- R8: After a clear, the alert stays low while the tripping temperature is still presented without convDone. It returns on the next tripping conversion.
- R9: When a tripping conversion and a clear (statusRead or alertAck) arrive in the same cycle, the trip wins. The flag and the alert are set.
- R10: Changes of convTemp or of the limit codes without convDone have no effect on the flags or the alert.
- R11: After reset, statusBits is 0 and both alert outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convDone | input | 1 | One-cycle pulse: convTemp holds a new result |
| convTemp | input | 16 | Signed temperature, 0.01 °C per LSB |
| hiLimitCode | input | 8 | Upper trip code, 0 disables |
| loLimitCode | input | 8 | Lower trip code, 0 disables |
| statusRead | input | 1 | Pulse: status byte is being read, clears flags and alert |
| alertAck | input | 1 | Pulse: alert response acknowledged, clears alert |
| statusBits | output | 8 | Status byte, bit 1 over, bit 2 under |
| alertPullLow | output | 1 | Enable for the open-drain driver, 1 pulls the pin low |
| alertPending | output | 1 | Alert is latched and awaiting a response |

## Verification
Temperatures are placed one LSB on either side of decoded trip points at the bottom, middle and top of the code range. These cases separate an inclusive upper compare from a strict lower one, and signed decoding from unsigned decoding. The extreme 16-bit values are applied with both codes at zero to show that zero disables a trip point, rather than acting as a very low limit. Clears are sent alone and in the same cycle as a tripping conversion, which separates set-wins priority from clear-wins priority. Holding a tripping temperature without convDone after a clear shows whether the alert re-arms at once or only at the next conversion.

// File: rtl/alert_pkg.sv
package alert_pkg;
  // Strobes the control side hands to the datapath
  typedef struct packed {
    logic capture;     // evaluate comparators this cycle
    logic clearFlags;  // status byte read
  } dpStrobe_t;

  typedef enum logic {
    ALERT_IDLE = 1'b0,
    ALERT_SET  = 1'b1
  } alertState_t;
endpackage

// File: rtl/alert_limit_chan.sv
module alert_limit_chan #(
  parameter int TEMP_W     = 16,
  parameter int LIM_W      = 8,
  parameter int LIM_OFFSET = 63,
  parameter int STEP_SHIFT = 6,
  parameter bit IS_HIGH    = 1'b1
) (
  input  logic [LIM_W-1:0]         limCode,
  input  logic signed [TEMP_W-1:0] temp,
  output logic                     hit
);
  localparam int CMP_W = TEMP_W + 1;
  localparam logic signed [CMP_W-1:0] OFFS = CMP_W'(LIM_OFFSET);

  logic signed [CMP_W-1:0] codeExt;
  logic signed [CMP_W-1:0] limVal;
  logic signed [CMP_W-1:0] tempExt;
  logic cmpHit;

  always_comb begin
    codeExt = {{(CMP_W-LIM_W){1'b0}}, limCode};
    limVal  = (codeExt - OFFS) <<< STEP_SHIFT;
    tempExt = {temp[TEMP_W-1], temp};
  end

  generate
    if (IS_HIGH) begin : g_high
      always_comb cmpHit = (tempExt >= limVal);
    end else begin : g_low
      always_comb cmpHit = (tempExt < limVal);
    end
  endgenerate

  always_comb hit = (limCode != '0) && cmpHit;
endmodule

// File: rtl/alert_datapath.sv
module alert_datapath
  import alert_pkg::*;
#(
  parameter int TEMP_W     = 16,
  parameter int LIM_W      = 8,
  parameter int LIM_OFFSET = 63,
  parameter int STEP_SHIFT = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic signed [TEMP_W-1:0] temp,
  input  logic [LIM_W-1:0]         hiCode,
  input  logic [LIM_W-1:0]         loCode,
  output logic                     hiHit,
  output logic                     loHit,
  output logic                     overFlag,
  output logic                     underFlag
);
  localparam int N_CH = 2;  // channel 0 = high, channel 1 = low

  logic [LIM_W-1:0] chCode [N_CH];
  logic [N_CH-1:0]  chHit;
  logic [N_CH-1:0]  chFlag;

  always_comb begin
    chCode[0] = hiCode;
    chCode[1] = loCode;
  end

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      alert_limit_chan #(
        .TEMP_W(TEMP_W), .LIM_W(LIM_W), .LIM_OFFSET(LIM_OFFSET),
        .STEP_SHIFT(STEP_SHIFT), .IS_HIGH(ch == 0)
      ) i_chan (
        .limCode(chCode[ch]),
        .temp   (temp),
        .hit    (chHit[ch])
      );

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                              chFlag[ch] <= 1'b0;
        else if (strobe.capture && chHit[ch])   chFlag[ch] <= 1'b1;
        else if (strobe.clearFlags)             chFlag[ch] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    hiHit     = chHit[0];
    loHit     = chHit[1];
    overFlag  = chFlag[0];
    underFlag = chFlag[1];
  end

  // R5: a read with no new conversion leaves both flags clear
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearFlags && !strobe.capture) |=> (!overFlag && !underFlag));

  // R4: flags are sticky while not read
  p_sticky_over_r4: assert property (@(posedge clk) disable iff (!rstN)
    (overFlag && !strobe.clearFlags) |=> overFlag);

  // R2: a disabled upper limit never raises the over flag
  p_hi_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    (hiCode == '0 && !overFlag) |=> !overFlag);

  // R10: without a capture strobe, flags never rise
  p_no_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !underFlag) |=> !underFlag);
endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
  import alert_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      convDone,
  input  logic      statusRead,
  input  logic      alertAck,
  input  logic      hiHit,
  input  logic      loHit,
  output dpStrobe_t strobe,
  output logic      alertLatched
);
  alertState_t state;
  logic tripNow;
  logic clearNow;

  always_comb begin
    strobe.capture    = convDone;
    strobe.clearFlags = statusRead;
    tripNow  = convDone && (hiHit || loHit);
    clearNow = statusRead || alertAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         state <= ALERT_IDLE;
    else if (tripNow)  state <= ALERT_SET;
    else if (clearNow) state <= ALERT_IDLE;
  end

  always_comb alertLatched = (state == ALERT_SET);

  // R6: alert holds until a clear arrives
  p_alert_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (alertLatched && !statusRead && !alertAck) |=> alertLatched);

  // R8: a clear without a conversion leaves the alert low
  p_no_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((statusRead || alertAck) && !convDone) |=> !alertLatched);

  // R9: a tripping conversion wins over any clear in the same cycle
  p_trip_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && (hiHit || loHit)) |=> alertLatched);
endmodule

// File: rtl/temp_alert_top.sv
module temp_alert_top
  import alert_pkg::*;
#(
  parameter int TEMP_W     = 16,
  parameter int LIM_W      = 8,
  parameter int LIM_OFFSET = 63,
  parameter int STEP_SHIFT = 6,
  parameter int STAT_W     = 8,
  parameter int OVER_BIT   = 1,
  parameter int UNDER_BIT  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [TEMP_W-1:0] convTemp,
  input  logic [LIM_W-1:0]  hiLimitCode,
  input  logic [LIM_W-1:0]  loLimitCode,
  input  logic              statusRead,
  input  logic              alertAck,
  output logic [STAT_W-1:0] statusBits,
  output logic              alertPullLow,
  output logic              alertPending
);
  dpStrobe_t strobe;
  logic hiHit, loHit, overFlag, underFlag, alertLatched;

  alert_datapath #(
    .TEMP_W(TEMP_W), .LIM_W(LIM_W), .LIM_OFFSET(LIM_OFFSET), .STEP_SHIFT(STEP_SHIFT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .temp(convTemp),
    .hiCode(hiLimitCode), .loCode(loLimitCode),
    .hiHit(hiHit), .loHit(loHit), .overFlag(overFlag), .underFlag(underFlag)
  );

  alert_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .convDone(convDone), .statusRead(statusRead),
    .alertAck(alertAck), .hiHit(hiHit), .loHit(loHit),
    .strobe(strobe), .alertLatched(alertLatched)
  );

  always_comb begin
    statusBits            = '0;
    statusBits[OVER_BIT]  = overFlag;
    statusBits[UNDER_BIT] = underFlag;
    alertPullLow          = alertLatched;
    alertPending          = alertLatched;
  end

  // R7: an acknowledge alone does not disturb the status flags
  p_ack_keeps_flags_r7: assert property (@(posedge clk) disable iff (!rstN)
    (alertAck && !statusRead && !convDone) |=> $stable(statusBits));
endmodule

// File: tb/test_temp_alert_top.sv
module test_temp_alert_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic convDone = 1'b0;
  logic [15:0] convTemp = '0;
  logic [7:0] hiLimitCode = '0;
  logic [7:0] loLimitCode = '0;
  logic statusRead = 1'b0;
  logic alertAck = 1'b0;
  logic [7:0] statusBits;
  logic alertPullLow;
  logic alertPending;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  temp_alert_top i_temp_alert_top (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convTemp(convTemp),
    .hiLimitCode(hiLimitCode), .loLimitCode(loLimitCode),
    .statusRead(statusRead), .alertAck(alertAck),
    .statusBits(statusBits), .alertPullLow(alertPullLow), .alertPending(alertPending)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // expected status byte and alert from the requirements
  task automatic expectState(input string req, input bit ov, input bit un, input bit al);
    check({req, " status"}, int'(statusBits), (int'(ov) << 1) | (int'(un) << 2));
    check({req, " pin"}, int'(alertPullLow), int'(al));
    check({req, " pending"}, int'(alertPending), int'(al));
  endtask

  function automatic int decodeLimit(input int code);
    return (code - 63) * 64;
  endfunction

  task automatic convert(input int t);
    @(negedge clk);
    convDone = 1'b1;
    convTemp = 16'(t);
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk);
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic ackAlert();
    @(negedge clk);
    alertAck = 1'b1;
    @(negedge clk);
    alertAck = 1'b0;
  endtask

  task automatic clearAll();
    readStatus();
  endtask

  task automatic testReset();
    expectState("R11", 0, 0, 0);
  endtask

  task automatic testHighEdge();
    hiLimitCode = 8'd63; loLimitCode = 8'd0;
    convert(decodeLimit(63));       expectState("R1 at 0", 1, 0, 1);
    clearAll();
    convert(decodeLimit(63) - 1);   expectState("R1 below 0", 0, 0, 0);
    hiLimitCode = 8'd255;
    convert(decodeLimit(255));      expectState("R1 top", 1, 0, 1);
    clearAll();
    convert(decodeLimit(255) - 1);  expectState("R1 top-1", 0, 0, 0);
    hiLimitCode = 8'd1;
    convert(decodeLimit(1));        expectState("R1 bottom", 1, 0, 1);
    clearAll();
    hiLimitCode = 8'd0;
  endtask

  task automatic testDisabled();
    hiLimitCode = 8'd0; loLimitCode = 8'd0;
    convert(32767);   expectState("R2 max", 0, 0, 0);
    convert(-32768);  expectState("R2 min", 0, 0, 0);
  endtask

  task automatic testLowEdge();
    loLimitCode = 8'd1;
    convert(decodeLimit(1));        expectState("R3 at -3968", 0, 0, 0);
    convert(decodeLimit(1) - 1);    expectState("R3 below", 0, 1, 1);
    clearAll();
    loLimitCode = 8'd100;
    convert(decodeLimit(100) - 1);  expectState("R3 mid", 0, 1, 1);
    clearAll();
    convert(decodeLimit(100));      expectState("R3 mid eq", 0, 0, 0);
    loLimitCode = 8'd0;
  endtask

  task automatic testStickyAndClear();
    hiLimitCode = 8'd70; loLimitCode = 8'd60;
    convert(decodeLimit(70) + 5);   expectState("R4 over set", 1, 0, 1);
    convert(decodeLimit(60) - 1);   expectState("R4 both", 1, 1, 1);
    convert(decodeLimit(65));       expectState("R4 sticky", 1, 1, 1);
    readStatus();                   expectState("R5 cleared", 0, 0, 0);
  endtask

  task automatic testAck();
    hiLimitCode = 8'd70; loLimitCode = 8'd0;
    convert(decodeLimit(70));       expectState("R6 set", 1, 0, 1);
    repeat (3) @(negedge clk);
    expectState("R6 held", 1, 0, 1);
    ackAlert();                     expectState("R7 ack", 1, 0, 0);
    repeat (4) @(negedge clk);
    expectState("R8 no rearm", 1, 0, 0);
    convert(decodeLimit(70));       expectState("R8 rearm", 1, 0, 1);
    readStatus();                   expectState("R8 read", 0, 0, 0);
    repeat (3) @(negedge clk);
    expectState("R8 still low", 0, 0, 0);
  endtask

  task automatic testPriority();
    hiLimitCode = 8'd70; loLimitCode = 8'd0;
    @(negedge clk);
    convDone = 1'b1; convTemp = 16'(decodeLimit(70) + 1); statusRead = 1'b1;
    @(negedge clk);
    convDone = 1'b0; statusRead = 1'b0;
    expectState("R9 read+trip", 1, 0, 1);
    clearAll();
    @(negedge clk);
    convDone = 1'b1; alertAck = 1'b1;
    @(negedge clk);
    convDone = 1'b0; alertAck = 1'b0;
    expectState("R9 ack+trip", 1, 0, 1);
    clearAll();
  endtask

  task automatic testNoCapture();
    hiLimitCode = 8'd63; loLimitCode = 8'd0;
    convert(-100);                  expectState("R10 base", 0, 0, 0);
    @(negedge clk);
    convTemp = 16'd5000;
    loLimitCode = 8'd255;
    repeat (3) @(negedge clk);
    expectState("R10 no conv", 0, 0, 0);
    loLimitCode = 8'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHighEdge();
    testDisabled();
    testLowEdge();
    testStickyAndClear();
    testAck();
    testPriority();
    testNoCapture();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule